// File: doc/BRIEF.md
# Dual-Output Timer Compare Channel

This block is one compare channel of a timer. It takes the value of a free-running counter that lives outside the block and compares it with a programmable compare value. From that comparison it builds an active-high reference level, and from the reference it drives a primary pin. A second pin can be driven in one of three ways: by its own independent compare path, as an exact copy of the primary pin, or as the complement of the primary reference with dead time inserted between the two. In that last case the primary is delayed by the same dead time, so the pair can drive the high and low switches of a half bridge without overlap.

All ports are plain level signals sampled on the rising clock edge. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. Compare values are double-buffered. Software may write them at any time, but the channel uses a new value only after a counter-overflow update event.

Top module: `twin_compare_channel`

## Requirements
- R1: Each channel holds an active compare value that loads from its compare input only in a cycle where `upd_evt` is high. Changes to a compare input at any other time have no effect on the pins.
- R2: Compare modes 3'd1 (set), 3'd2 (clear) and 3'd3 (toggle) make the reference go high, go low or invert on the clock edge where the counter equals the active compare value. They hold it at every other edge.
- R3: Mode 3'd0 (frozen) holds the reference whatever the counter does. Mode 3'd4 forces it low and mode 3'd5 forces it high at the next edge.
- R4: Mode 3'd6 makes the reference high when counter < compare value. Mode 3'd7 makes it high when counter >= compare value. The reference is registered from the counter and compare values present at the edge.
- R5: The primary pin equals `pri_en & (source ^ pri_pol)`. When the channel is disabled the pin drives 0, and a polarity bit of 1 makes the active level low.
- R6: With `sec_sel`=2'b00, the secondary pin follows its own compare path, built from `sec_cmp_val` and `sec_mode`. It equals `sec_en & ((ref & ~sec_pol[1]) ^ sec_pol[0])`: bit 0 inverts and bit 1 masks the reference.
- R7: With `sec_sel`=2'b01, the secondary pin equals the primary pin exactly, whatever `sec_en` and `sec_pol` hold.
- R8: With `sec_sel`=2'b10 (reserved), the secondary pin sits at its inactive level, `sec_en & sec_pol[0]`.
- R9: With `sec_sel`=2'b11, the primary source is the dead-time-delayed primary reference and the secondary source is its delayed complement. The two delayed signals are never high together.
- R10: A reference change drops the side that was active one edge after the reference register changes. The side that becomes active rises `dead_clks` edges after that drop; with `dead_clks`=0 it switches at the same edge.
- R11: A reference pulse that lasts no longer than the dead time never appears on the delayed side it would have activated.
- R12: After reset, both references and the active compare values are 0, so with mode frozen and polarity 0 both pins read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt | input | CW | Counter value |
| upd_evt | input | 1 | Overflow update event; loads both compare values |
| pri_cmp_val | input | CW | Primary compare value (buffered) |
| sec_cmp_val | input | CW | Secondary compare value (buffered) |
| pri_mode | input | 3 | Primary compare mode |
| sec_mode | input | 3 | Secondary compare mode |
| sec_sel | input | 2 | Secondary source select |
| pri_pol | input | 1 | Primary polarity, 1 = active low |
| pri_en | input | 1 | Primary output enable |
| sec_pol | input | 2 | Secondary polarity: bit 0 invert, bit 1 mask |
| sec_en | input | 1 | Secondary output enable |
| dead_clks | input | DTW | Dead time in clocks |
| pri_pin | output | 1 | Primary pin level |
| sec_pin | output | 1 | Secondary pin level |

## Verification
A counter, compare value or mode applied before an edge shows up on the reference, and so on the pins, right after that edge. An update event loads the compare value at its edge, so the new value first takes part in the comparison at the following edge. Polarity, enable and source select act combinationally, so the bench checks them a moment after it drives them. The dead-time path adds one edge to detect the change plus `dead_clks` edges for the rising side. The bench therefore counts edges from the mode change and samples at exactly edge 1+D and edge 2+D. All stimulus and sampling happen 2 ns after a rising edge.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [2:0] {
    CM_FROZEN = 3'd0,
    CM_SET    = 3'd1,
    CM_CLEAR  = 3'd2,
    CM_TOGGLE = 3'd3,
    CM_LOW    = 3'd4,
    CM_HIGH   = 3'd5,
    CM_PWM_LO = 3'd6,
    CM_PWM_HI = 3'd7
  } cmp_mode_e;

  typedef enum logic [1:0] {
    SEC_INDEP  = 2'b00,
    SEC_MIRROR = 2'b01,
    SEC_RSVD   = 2'b10,
    SEC_COMPL  = 2'b11
  } sec_sel_e;
endpackage

// File: rtl/tcc_ref_gen.sv
module tcc_ref_gen
  import tcc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_evt,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp_in,
  input  cmp_mode_e     mode,
  output logic          ref_o
);
  logic [CW-1:0] act_cmp;
  logic          gt, eq, lt;
  logic          ref_q, ref_d;

  // buffered compare value, loaded only at the update event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_cmp <= '0;
    else if (upd_evt) act_cmp <= cmp_in;
  end

  // three-way comparator
  always_comb begin
    gt = cnt > act_cmp;
    eq = cnt == act_cmp;
    lt = cnt < act_cmp;
  end

  always_comb begin
    ref_d = ref_q;
    unique case (mode)
      CM_FROZEN: ref_d = ref_q;
      CM_SET:    if (eq) ref_d = 1'b1;
      CM_CLEAR:  if (eq) ref_d = 1'b0;
      CM_TOGGLE: if (eq) ref_d = ~ref_q;
      CM_LOW:    ref_d = 1'b0;
      CM_HIGH:   ref_d = 1'b1;
      CM_PWM_LO: ref_d = lt;
      CM_PWM_HI: ref_d = gt | eq;
      default:   ref_d = ref_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_d;
  end

  assign ref_o = ref_q;

  assert_cmp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(upd_evt) |-> $stable(act_cmp));
  assert_set_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_SET && eq) |=> ref_q);
  assert_clear_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_CLEAR && eq) |=> !ref_q);
  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_FROZEN) |=> $stable(ref_q));
  assert_pwm_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_PWM_LO) |=> (ref_q == $past(lt)));
endmodule

// File: rtl/tcc_deadtime.sv
module tcc_deadtime #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           src,
  input  logic [DTW-1:0] dead,
  output logic           pos_o,
  output logic           neg_o
);
  localparam logic [DTW-1:0] ONE = DTW'(1);

  logic           last;
  logic [DTW-1:0] hold;
  logic           pos_q, neg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last  <= 1'b0;
      hold  <= '0;
      pos_q <= 1'b0;
      neg_q <= 1'b0;
    end else if (src != last) begin
      // source moved: drop both sides and restart the guard interval
      last <= src;
      hold <= dead;
      if (dead == '0) begin
        pos_q <= src;
        neg_q <= ~src;
      end else begin
        pos_q <= 1'b0;
        neg_q <= 1'b0;
      end
    end else if (hold != '0) begin
      hold <= hold - ONE;
      if (hold == ONE) begin
        pos_q <= last;
        neg_q <= ~last;
      end
    end else begin
      pos_q <= last;
      neg_q <= ~last;
    end
  end

  assign pos_o = pos_q;
  assign neg_o = neg_q;

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_q && neg_q));
  assert_pos_settled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q |-> last);
  assert_neg_settled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    neg_q |-> !last);
  assert_drop_on_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (src != last && dead != '0) |=> (!pos_q && !neg_q));
endmodule

// File: rtl/tcc_pin_gate.sv
module tcc_pin_gate (
  input  logic src,
  input  logic en,
  input  logic inv,
  input  logic mask,
  output logic pin
);
  assign pin = en & ((src & ~mask) ^ inv);
endmodule

// File: rtl/twin_compare_channel.sv
module twin_compare_channel
  import tcc_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  cnt,
  input  logic           upd_evt,
  input  logic [CW-1:0]  pri_cmp_val,
  input  logic [CW-1:0]  sec_cmp_val,
  input  logic [2:0]     pri_mode,
  input  logic [2:0]     sec_mode,
  input  logic [1:0]     sec_sel,
  input  logic           pri_pol,
  input  logic           pri_en,
  input  logic [1:0]     sec_pol,
  input  logic           sec_en,
  input  logic [DTW-1:0] dead_clks,
  output logic           pri_pin,
  output logic           sec_pin
);
  logic     ref_p, ref_s, dt_p, dt_n;
  logic     pri_src, sec_src, sec_gated;
  sec_sel_e sel;

  assign sel = sec_sel_e'(sec_sel);

  tcc_ref_gen #(.CW(CW)) u_ref_pri (
    .clk(clk), .rst_n(rst_n), .upd_evt(upd_evt), .cnt(cnt),
    .cmp_in(pri_cmp_val), .mode(cmp_mode_e'(pri_mode)), .ref_o(ref_p));

  tcc_ref_gen #(.CW(CW)) u_ref_sec (
    .clk(clk), .rst_n(rst_n), .upd_evt(upd_evt), .cnt(cnt),
    .cmp_in(sec_cmp_val), .mode(cmp_mode_e'(sec_mode)), .ref_o(ref_s));

  tcc_deadtime #(.DTW(DTW)) u_dead (
    .clk(clk), .rst_n(rst_n), .src(ref_p), .dead(dead_clks),
    .pos_o(dt_p), .neg_o(dt_n));

  always_comb begin
    pri_src = (sel == SEC_COMPL) ? dt_p : ref_p;
    unique case (sel)
      SEC_INDEP: sec_src = ref_s;
      SEC_COMPL: sec_src = dt_n;
      default:   sec_src = 1'b0;
    endcase
  end

  tcc_pin_gate u_gate_pri (
    .src(pri_src), .en(pri_en), .inv(pri_pol), .mask(1'b0), .pin(pri_pin));

  tcc_pin_gate u_gate_sec (
    .src(sec_src), .en(sec_en), .inv(sec_pol[0]), .mask(sec_pol[1]),
    .pin(sec_gated));

  assign sec_pin = (sel == SEC_MIRROR) ? pri_pin : sec_gated;

  assert_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEC_MIRROR) |-> (sec_pin == pri_pin));
  assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEC_RSVD) |-> (sec_pin == (sec_en & sec_pol[0])));
  assert_compl_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEC_COMPL && pri_en && sec_en && !pri_pol && sec_pol == 2'b00)
      |-> !(pri_pin && sec_pin));
endmodule

// File: tb/twin_compare_channel_test.sv
module twin_compare_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic        upd_evt = 1'b0;
  logic [15:0] pri_cmp_val = '0, sec_cmp_val = '0;
  logic [2:0]  pri_mode = 3'd0, sec_mode = 3'd0;
  logic [1:0]  sec_sel = 2'b00;
  logic        pri_pol = 1'b0, pri_en = 1'b1;
  logic [1:0]  sec_pol = 2'b00;
  logic        sec_en = 1'b1;
  logic [7:0]  dead_clks = '0;
  logic        pri_pin, sec_pin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  twin_compare_channel uut (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .upd_evt(upd_evt),
    .pri_cmp_val(pri_cmp_val), .sec_cmp_val(sec_cmp_val),
    .pri_mode(pri_mode), .sec_mode(sec_mode), .sec_sel(sec_sel),
    .pri_pol(pri_pol), .pri_en(pri_en), .sec_pol(sec_pol), .sec_en(sec_en),
    .dead_clks(dead_clks), .pri_pin(pri_pin), .sec_pin(sec_pin));

  typedef struct packed {
    logic [2:0]  mode;
    logic [15:0] cmp;
    logic [15:0] cval;
    logic        pol;
    logic        exp;
  } vec_t;

  // R4 / R5 / R3 stateless vectors
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'd6, 16'd10,     16'd5,      1'b0, 1'b1},
    '{3'd6, 16'd10,     16'd10,     1'b0, 1'b0},
    '{3'd6, 16'd10,     16'd11,     1'b0, 1'b0},
    '{3'd7, 16'd10,     16'd10,     1'b0, 1'b1},
    '{3'd7, 16'd10,     16'd9,      1'b0, 1'b0},
    '{3'd6, 16'd10,     16'd5,      1'b1, 1'b0},
    '{3'd5, 16'd0,      16'd0,      1'b0, 1'b1},
    '{3'd4, 16'd0,      16'd5,      1'b0, 1'b0},
    '{3'd6, 16'd0,      16'd0,      1'b0, 1'b0},
    '{3'd7, 16'd0,      16'd0,      1'b0, 1'b1},
    '{3'd6, 16'hFFFF,   16'hFFFE,   1'b0, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic load_cmp();
    upd_evt = 1'b1;
    tick();
    upd_evt = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R12 pri after reset", pri_pin, 1'b0);
    chk("R12 sec after reset", sec_pin, 1'b0);
    pri_pol = 1'b1; #1;
    chk("R5 polarity inverts idle", pri_pin, 1'b1);
    pri_en = 1'b0; #1;
    chk("R5 disabled drives 0", pri_pin, 1'b0);
    pri_en = 1'b1; pri_pol = 1'b0;

    // R4 table walk
    for (int i = 0; i < NV; i++) begin
      pri_cmp_val = VECS[i].cmp;
      load_cmp();
      pri_mode = VECS[i].mode;
      pri_pol  = VECS[i].pol;
      cnt      = VECS[i].cval;
      tick();
      chk($sformatf("R4 vector %0d", i), pri_pin, VECS[i].exp);
    end
    pri_pol = 1'b0;

    // R2 / R3 match-driven modes
    pri_cmp_val = 16'd7; load_cmp();
    pri_mode = 3'd4; tick();
    pri_mode = 3'd1; cnt = 16'd3; tick();
    chk("R2 set no match", pri_pin, 1'b0);
    cnt = 16'd7; tick();
    chk("R2 set on match", pri_pin, 1'b1);
    cnt = 16'd8; tick();
    chk("R2 set holds", pri_pin, 1'b1);
    pri_mode = 3'd0; cnt = 16'd7; tick();
    chk("R3 frozen holds", pri_pin, 1'b1);
    pri_mode = 3'd2; tick();
    chk("R2 clear on match", pri_pin, 1'b0);
    pri_mode = 3'd3; tick();
    chk("R2 toggle first", pri_pin, 1'b1);
    tick();
    chk("R2 toggle second", pri_pin, 1'b0);

    // R1 buffered compare
    pri_cmp_val = 16'd10; load_cmp();
    pri_cmp_val = 16'd3; pri_mode = 3'd6; cnt = 16'd5; tick();
    chk("R1 unbuffered write ignored", pri_pin, 1'b1);
    tick();
    chk("R1 still old value", pri_pin, 1'b1);
    upd_evt = 1'b1; tick(); upd_evt = 1'b0;
    chk("R1 update edge uses old value", pri_pin, 1'b1);
    tick();
    chk("R1 new value after update", pri_pin, 1'b0);

    // R6 independent secondary
    sec_cmp_val = 16'd10; load_cmp();
    sec_sel = 2'b00; sec_mode = 3'd6; cnt = 16'd5; pri_mode = 3'd4; tick();
    sec_en = 1'b1; sec_pol = 2'b00; #1;
    chk("R6 sec active", sec_pin, 1'b1);
    chk("R6 pri independent", pri_pin, 1'b0);
    sec_pol = 2'b01; #1; chk("R6 sec inverted", sec_pin, 1'b0);
    sec_pol = 2'b10; #1; chk("R6 sec masked", sec_pin, 1'b0);
    sec_pol = 2'b11; #1; chk("R6 sec masked inverted", sec_pin, 1'b1);
    sec_en = 1'b0; #1;   chk("R6 sec disabled", sec_pin, 1'b0);

    // R7 mirror
    sec_sel = 2'b01; pri_mode = 3'd5; tick();
    chk("R7 mirror high", sec_pin, 1'b1);
    pri_pol = 1'b1; #1;
    chk("R7 mirror follows polarity", sec_pin, 1'b0);
    pri_pol = 1'b0;

    // R8 reserved
    sec_sel = 2'b10; sec_en = 1'b1; sec_pol = 2'b01; sec_mode = 3'd5; tick();
    chk("R8 reserved inactive inverted", sec_pin, 1'b1);
    sec_pol = 2'b00; #1;
    chk("R8 reserved inactive", sec_pin, 1'b0);

    // R9 / R10 dead time D=3
    sec_sel = 2'b11; sec_pol = 2'b00; dead_clks = 8'd3;
    pri_mode = 3'd4; repeat (8) tick();
    chk("R9 settled low pri", pri_pin, 1'b0);
    chk("R9 settled complement", sec_pin, 1'b1);
    pri_mode = 3'd5;
    for (int k = 1; k <= 5; k++) begin
      tick();
      if (k == 2) chk("R10 complement drops", sec_pin, 1'b0);
      if (k == 4) chk("R10 pri still in dead time", pri_pin, 1'b0);
      if (k == 5) chk("R10 pri rises after dead time", pri_pin, 1'b1);
    end
    chk("R9 complement low while pri high", sec_pin, 1'b0);

    // R10 zero dead time
    dead_clks = 8'd0; pri_mode = 3'd4; repeat (4) tick();
    pri_mode = 3'd5; tick();
    chk("R10 zero dt before", pri_pin, 1'b0);
    tick();
    chk("R10 zero dt switches", pri_pin, 1'b1);

    // R11 short pulse suppressed, D=4
    dead_clks = 8'd4; pri_mode = 3'd4; repeat (8) tick();
    pri_mode = 3'd5; tick();
    pri_mode = 3'd4;
    begin
      logic seen = 1'b0;
      for (int k = 0; k < 10; k++) begin
        tick();
        if (pri_pin) seen = 1'b1;
      end
      chk("R11 short pulse suppressed", seen, 1'b0);
    end
    chk("R11 complement restored", sec_pin, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule